// File: doc/BRIEF.md
# Four-Lane Fixed-Point Vector ALU

This block is a SIMD arithmetic unit that works on 144-bit words. Each word holds four signed 36-bit fixed-point lanes (one sign bit, 35 fraction bits). Lanes 0 and 1 form a low complex number (real, imaginary), and lanes 2 and 3 form a high one. The unit decodes 18-bit instruction words. It reads two source registers and the destination register from a register file with 16 entries for each of four contexts. In the same clock edge that samples the instruction, it writes the result back.

The unit performs lane-wise multiply, add and subtract. It computes half-vector complex products, so a full complex multiply takes two instructions. It also copies a register, or copies it with its complex values conjugated. A preload port fills registers directly. A read port returns any register combinationally, which lets the surrounding logic or a bench see every result. An encoding that is not defined writes nothing and raises a one-cycle error flag.

Top module: `vec4_alu`

## Requirements
- R1: After a synchronous active-low reset, all 64 registers read zero and `illegal` is low.
- R2: When `ld_valid` is high at a rising edge, `ld_data` is written to register {`ld_ctx`,`ld_idx`}. If an instruction writes the same register at the same edge, the instruction result is kept.
- R3: Instruction fields are s = bits 3:0, t = bits 7:4, r = bits 13:11, transfer flag = bit 10, op = bits 16:14 and reserved = bit 17. Bits 9:8 are ignored. Sources are registers {`ctx`,t} and {`ctx`,s}. The destination is {`ctx`,0,r}, so only entries 0 to 7 of a context can be destinations. No other context is touched.
- R4: With op 001 and no transfer flag, each lane of the destination becomes ds×dt. The 72-bit signed product is shifted right arithmetically by 35 and truncated to 36 bits.
- R5: With op 010, each lane becomes ds+dt. With op 011, each lane becomes dt−ds. Both wrap modulo 2^36.
- R6: With op 100, lanes 0–1 of the destination become the complex product of the low number of t and the low number of s. With op 101, lanes 2–3 become the complex product of the low number of t and the high number of s. The other half of the destination keeps its old value. The real part is ar·br − ai·bi and the imaginary part is ar·bi + ai·br. Each is summed at full precision, then shifted right arithmetically by 35 and truncated.
- R7: With the transfer flag set, op 010 copies dt to the destination. Op 011 copies dt with lanes 1 and 3 negated (wrapping). Field s is ignored.
- R8: The following encodings are undefined: reserved bit set, op 000/110/111 without transfer, and any op other than 010/011 with transfer. For these, no register changes and `illegal` is high for exactly the cycle after the instruction.
- R9: A result is visible on `rd_data` right after the edge that samples `instr_valid`. Without a valid instruction or a load, all registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_valid | input | 1 | Instruction strobe |
| instr | input | 18 | Instruction word |
| ctx | input | 2 | Context of the instruction |
| ld_valid | input | 1 | Preload strobe |
| ld_ctx | input | 2 | Preload context |
| ld_idx | input | 4 | Preload register index |
| ld_data | input | 144 | Preload value |
| rd_ctx | input | 2 | Read-back context |
| rd_idx | input | 4 | Read-back register index |
| rd_data | output | 144 | Read-back value, combinational |
| illegal | output | 1 | Undefined-encoding flag, one cycle |

## Verification
Register results, preloads and the error flag are all due one rising edge after the bench drives its stimulus. The bench therefore changes inputs on a falling edge and samples on the next falling edge plus a small delay. Because read-back is combinational, the bench moves the read address and samples again after that delay, so no check lands on the active edge. At each step it compares the flag, and the destination and preload registers, against a behavioural model. It sweeps all 64 registers after reset, after idle cycles and at the end.

// File: rtl/vec4_pkg.sv
// Package: shared instruction field positions, operation kinds and the
// decoded-instruction record used by the four-lane vector ALU.
package vec4_pkg;

    localparam int INSTR_W   = 18;
    localparam int F_S_LSB   = 0;
    localparam int F_T_LSB   = 4;
    localparam int F_XFER    = 10;
    localparam int F_R_LSB   = 11;
    localparam int F_OP_LSB  = 14;
    localparam int F_RSV     = 17;
    localparam int SRC_W     = 4;
    localparam int DST_W     = 3;
    localparam int OPF_W     = 3;

    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_MUL  = 3'd1,
        K_ADD  = 3'd2,
        K_SUB  = 3'd3,
        K_CML  = 3'd4,
        K_CMH  = 3'd5,
        K_CPY  = 3'd6,
        K_CNJ  = 3'd7
    } op_kind_e;

    typedef struct packed {
        op_kind_e           kind;
        logic               bad;
        logic [DST_W-1:0]   r;
        logic [SRC_W-1:0]   t;
        logic [SRC_W-1:0]   s;
    } dec_t;

endpackage

// File: rtl/vec4_cmul.sv
// Complex multiplier for one pair of fixed-point lanes.
// Assumes signed lanes of W bits with FRAC fraction bits; both sums are
// formed at full precision before the arithmetic shift and truncation.
module vec4_cmul #(
    parameter int W    = 36,
    parameter int FRAC = 35
) (
    input  logic [W-1:0] ar,
    input  logic [W-1:0] ai,
    input  logic [W-1:0] br,
    input  logic [W-1:0] bi,
    output logic [W-1:0] re,
    output logic [W-1:0] im
);
    localparam int PW = 2 * W + 1;

    logic signed [PW-1:0] sum_re;
    logic signed [PW-1:0] sum_im;

    // full-precision real and imaginary sums
    assign sum_re = PW'($signed(ar)) * PW'($signed(br)) - PW'($signed(ai)) * PW'($signed(bi));
    assign sum_im = PW'($signed(ar)) * PW'($signed(bi)) + PW'($signed(ai)) * PW'($signed(br));

    // scale back to lane format by dropping fraction bits and the top
    assign re = sum_re[FRAC+W-1:FRAC];
    assign im = sum_im[FRAC+W-1:FRAC];

    logic unused_cm;
    assign unused_cm = ^{sum_re[PW-1:FRAC+W], sum_re[FRAC-1:0],
                         sum_im[PW-1:FRAC+W], sum_im[FRAC-1:0]};
endmodule

// File: rtl/vec4_lanes.sv
// Four-lane datapath: lane-wise multiply/add/subtract, half-vector complex
// products, copy and conjugate. Purely combinational. Assumes lanes 0/1
// and 2/3 are (real, imaginary) pairs; vd supplies untouched lanes.
module vec4_lanes
    import vec4_pkg::*;
#(
    parameter int LANE_W = 36,
    parameter int FRAC   = 35
) (
    input  op_kind_e                kind,
    input  logic [4*LANE_W-1:0]     vt,
    input  logic [4*LANE_W-1:0]     vs,
    input  logic [4*LANE_W-1:0]     vd,
    output logic [4*LANE_W-1:0]     res
);
    localparam int LANES = 4;
    localparam int PAIR_W = 2 * LANE_W;

    logic [PAIR_W-1:0] cm_lo;
    logic [PAIR_W-1:0] cm_hi;

    // low(t) x low(s) for the lower half of the destination
    vec4_cmul #(.W(LANE_W), .FRAC(FRAC)) u_cm_lo (
        .ar (vt[0*LANE_W +: LANE_W]),
        .ai (vt[1*LANE_W +: LANE_W]),
        .br (vs[0*LANE_W +: LANE_W]),
        .bi (vs[1*LANE_W +: LANE_W]),
        .re (cm_lo[0 +: LANE_W]),
        .im (cm_lo[LANE_W +: LANE_W])
    );

    // low(t) x high(s) for the upper half of the destination
    vec4_cmul #(.W(LANE_W), .FRAC(FRAC)) u_cm_hi (
        .ar (vt[0*LANE_W +: LANE_W]),
        .ai (vt[1*LANE_W +: LANE_W]),
        .br (vs[2*LANE_W +: LANE_W]),
        .bi (vs[3*LANE_W +: LANE_W]),
        .re (cm_hi[0 +: LANE_W]),
        .im (cm_hi[LANE_W +: LANE_W])
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam bit IS_IM = (k % 2) == 1;
        localparam bit IS_HI = k >= 2;

        logic [LANE_W-1:0]          a_t;
        logic [LANE_W-1:0]          a_s;
        logic [LANE_W-1:0]          a_d;
        logic [LANE_W-1:0]          a_cm;
        logic signed [PAIR_W-1:0]   prod;
        logic [LANE_W-1:0]          y;

        assign a_t  = vt[k*LANE_W +: LANE_W];
        assign a_s  = vs[k*LANE_W +: LANE_W];
        assign a_d  = vd[k*LANE_W +: LANE_W];
        assign a_cm = IS_HI ? cm_hi[(k%2)*LANE_W +: LANE_W]
                            : cm_lo[(k%2)*LANE_W +: LANE_W];

        // signed lane product at full width
        assign prod = PAIR_W'($signed(a_t)) * PAIR_W'($signed(a_s));

        // select the lane result for the decoded operation
        always_comb begin
            unique case (kind)
                K_MUL:   y = prod[FRAC+LANE_W-1:FRAC];
                K_ADD:   y = a_s + a_t;
                K_SUB:   y = a_t - a_s;
                K_CML:   y = IS_HI ? a_d : a_cm;
                K_CMH:   y = IS_HI ? a_cm : a_d;
                K_CPY:   y = a_t;
                K_CNJ:   y = IS_IM ? (LANE_W'(0) - a_t) : a_t;
                default: y = a_d;
            endcase
        end

        assign res[k*LANE_W +: LANE_W] = y;

        logic unused_prod;
        assign unused_prod = ^{prod[PAIR_W-1:FRAC+LANE_W], prod[FRAC-1:0]};
    end
endmodule

// File: rtl/vec4_decode.sv
// Instruction decoder: splits the 18-bit word into register fields and an
// operation kind, and marks undefined encodings. Bits 9:8 carry nothing.
module vec4_decode
    import vec4_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    logic [OPF_W-1:0] opf;
    logic             xfer;
    logic             rsv;

    assign opf  = instr[F_OP_LSB +: OPF_W];
    assign xfer = instr[F_XFER];
    assign rsv  = instr[F_RSV];

    // map opcode and transfer flag onto an operation kind
    always_comb begin
        dec.s    = instr[F_S_LSB +: SRC_W];
        dec.t    = instr[F_T_LSB +: SRC_W];
        dec.r    = instr[F_R_LSB +: DST_W];
        dec.kind = K_NONE;
        if (xfer) begin
            unique case (opf)
                3'b010:  dec.kind = K_CPY;
                3'b011:  dec.kind = K_CNJ;
                default: dec.kind = K_NONE;
            endcase
        end else begin
            unique case (opf)
                3'b001:  dec.kind = K_MUL;
                3'b010:  dec.kind = K_ADD;
                3'b011:  dec.kind = K_SUB;
                3'b100:  dec.kind = K_CML;
                3'b101:  dec.kind = K_CMH;
                default: dec.kind = K_NONE;
            endcase
        end
        if (rsv) dec.kind = K_NONE;
        dec.bad = (dec.kind == K_NONE);
    end

    logic unused_dec;
    assign unused_dec = ^instr[9:8];
endmodule

// File: rtl/vec4_regfile.sv
// Register file with three combinational instruction read ports, one
// read-back port, an instruction write port and a preload write port.
// Assumes the instruction write takes priority on an address collision.
module vec4_regfile #(
    parameter int W  = 144,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic          le,
    input  logic [AW-1:0] la,
    input  logic [W-1:0]  ld,
    input  logic [AW-1:0] ra_t,
    input  logic [AW-1:0] ra_s,
    input  logic [AW-1:0] ra_d,
    input  logic [AW-1:0] ra_x,
    output logic [W-1:0]  rd_t,
    output logic [W-1:0]  rd_s,
    output logic [W-1:0]  rd_d,
    output logic [W-1:0]  rd_x
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    // clear on reset, then preload and instruction writes (latter wins)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (le) mem[la] <= ld;
            if (we) mem[wa] <= wd;
        end
    end

    assign rd_t = mem[ra_t];
    assign rd_s = mem[ra_s];
    assign rd_d = mem[ra_d];
    assign rd_x = mem[ra_x];
endmodule

// File: rtl/vec4_alu.sv
// Four-lane vector ALU top: decodes one instruction per cycle, reads its
// operands in the instruction's context, and writes the result at the same
// edge. Undefined encodings write nothing and pulse `illegal` next cycle.
module vec4_alu
    import vec4_pkg::*;
#(
    parameter int LANE_W = 36,
    parameter int FRAC   = 35,
    parameter int CTX_W  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_valid,
    input  logic [17:0]          instr,
    input  logic [CTX_W-1:0]     ctx,
    input  logic                 ld_valid,
    input  logic [CTX_W-1:0]     ld_ctx,
    input  logic [3:0]           ld_idx,
    input  logic [4*LANE_W-1:0]  ld_data,
    input  logic [CTX_W-1:0]     rd_ctx,
    input  logic [3:0]           rd_idx,
    output logic [4*LANE_W-1:0]  rd_data,
    output logic                 illegal
);
    localparam int DATA_W = 4 * LANE_W;
    localparam int AW     = CTX_W + SRC_W;

    dec_t              dec;
    logic [DATA_W-1:0] vt;
    logic [DATA_W-1:0] vs;
    logic [DATA_W-1:0] vd;
    logic [DATA_W-1:0] result;
    logic [AW-1:0]     dst_a;
    logic              wb_en;
    logic              illegal_q;

    vec4_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    assign dst_a = {ctx, 1'b0, dec.r};
    assign wb_en = instr_valid && !dec.bad;

    vec4_regfile #(.W(DATA_W), .AW(AW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wb_en),
        .wa    (dst_a),
        .wd    (result),
        .le    (ld_valid),
        .la    ({ld_ctx, ld_idx}),
        .ld    (ld_data),
        .ra_t  ({ctx, dec.t}),
        .ra_s  ({ctx, dec.s}),
        .ra_d  (dst_a),
        .ra_x  ({rd_ctx, rd_idx}),
        .rd_t  (vt),
        .rd_s  (vs),
        .rd_d  (vd),
        .rd_x  (rd_data)
    );

    vec4_lanes #(.LANE_W(LANE_W), .FRAC(FRAC)) u_lanes (
        .kind (dec.kind),
        .vt   (vt),
        .vs   (vs),
        .vd   (vd),
        .res  (result)
    );

    // one-cycle error pulse for an undefined encoding
    always_ff @(posedge clk) begin
        if (!rst_n) illegal_q <= 1'b0;
        else        illegal_q <= instr_valid && dec.bad;
    end

    assign illegal = illegal_q;
endmodule

// File: rtl/vec4_alu_chk.sv
// Assertion checker for vec4_alu, attached by bind below.
module vec4_alu_chk #(
    parameter int DATA_W = 144,
    parameter int CTX_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic [17:0]       instr,
    input logic              ld_valid,
    input logic [CTX_W-1:0]  rd_ctx,
    input logic [3:0]        rd_idx,
    input logic [DATA_W-1:0] rd_data,
    input logic              illegal,
    input logic              wb_en
);
    // R8: the flag only follows a presented instruction
    p_flag_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> $past(instr_valid));

    // R8: reserved bit set always raises the flag next cycle
    p_reserved_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && instr[17]) |=> illegal);

    // R9: no register write without a valid instruction
    p_write_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> instr_valid);

    // R7: a well-formed copy always writes back
    p_copy_writes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !instr[17] && instr[10] && instr[16:14] == 3'b010) |-> wb_en);

    // R9: with no write source, read-back of a fixed address holds
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!instr_valid && !ld_valid) && $stable(rd_ctx) && $stable(rd_idx))
        |-> $stable(rd_data));
endmodule

bind vec4_alu vec4_alu_chk #(.DATA_W(DATA_W), .CTX_W(CTX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .ld_valid    (ld_valid),
    .rd_ctx      (rd_ctx),
    .rd_idx      (rd_idx),
    .rd_data     (rd_data),
    .illegal     (illegal),
    .wb_en       (wb_en)
);

// File: tb/vec4_alu_bench.sv
module vec4_alu_bench;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         instr_valid = 1'b0;
    logic [17:0]  instr = '0;
    logic [1:0]   ctx = '0;
    logic         ld_valid = 1'b0;
    logic [1:0]   ld_ctx = '0;
    logic [3:0]   ld_idx = '0;
    logic [143:0] ld_data = '0;
    logic [1:0]   rd_ctx = '0;
    logic [3:0]   rd_idx = '0;
    logic [143:0] rd_data;
    logic         illegal;

    int n_chk = 0;
    int n_bad = 0;
    logic [143:0] m [64];

    localparam logic [35:0] HALF = 36'h4_0000_0000;
    localparam logic [35:0] QTR  = 36'h2_0000_0000;
    localparam logic [35:0] NHLF = 36'hC_0000_0000;
    localparam logic [35:0] MINV = 36'h8_0000_0000;
    localparam logic [35:0] MAXV = 36'h7_FFFF_FFFF;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec4_alu u_vec4_alu (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .ctx(ctx), .ld_valid(ld_valid), .ld_ctx(ld_ctx), .ld_idx(ld_idx),
        .ld_data(ld_data), .rd_ctx(rd_ctx), .rd_idx(rd_idx),
        .rd_data(rd_data), .illegal(illegal)
    );

    function automatic logic [17:0] mk(logic [2:0] op, logic xf, logic [2:0] r,
                                       logic [3:0] t, logic [3:0] s);
        return {1'b0, op, r, xf, 2'b00, t, s};
    endfunction

    function automatic logic [143:0] v4(logic [35:0] l3, logic [35:0] l2,
                                        logic [35:0] l1, logic [35:0] l0);
        return {l3, l2, l1, l0};
    endfunction

    function automatic logic [143:0] rnd144();
        logic [159:0] w;
        w = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
        return w[143:0];
    endfunction

    // fixed-point product, value-scaled by 2^-35, truncated toward -inf
    function automatic logic [35:0] fx_mul(logic [35:0] a, logic [35:0] b);
        logic signed [71:0] p;
        p = $signed(a) * $signed(b);
        p = p >>> 35;
        return p[35:0];
    endfunction

    task automatic fx_cm(input logic [35:0] ar, ai, br, bi,
                         output logic [35:0] re, output logic [35:0] im);
        logic signed [72:0] x;
        logic signed [72:0] y;
        x = $signed(ar) * $signed(br);
        x = x - $signed(ai) * $signed(bi);
        y = $signed(ar) * $signed(bi);
        y = y + $signed(ai) * $signed(br);
        x = x >>> 35;
        y = y >>> 35;
        re = x[35:0];
        im = y[35:0];
    endtask

    // behavioural model of one instruction against the model array
    task automatic predict(input logic [17:0] ins, input logic [1:0] c,
                           output bit bad, output logic [5:0] dst,
                           output logic [143:0] val);
        logic [35:0] t [4];
        logic [35:0] s [4];
        logic [35:0] re;
        logic [35:0] im;
        logic [143:0] vt, vs, vd;
        logic [2:0] op;
        op  = ins[16:14];
        dst = {c, 1'b0, ins[13:11]};
        vt  = m[{c, ins[7:4]}];
        vs  = m[{c, ins[3:0]}];
        vd  = m[dst];
        for (int k = 0; k < 4; k++) begin
            t[k] = vt[36*k +: 36];
            s[k] = vs[36*k +: 36];
        end
        bad = 1'b0;
        val = vd;
        if (ins[17]) bad = 1'b1;
        else if (ins[10]) begin
            if (op == 3'b010) val = vt;
            else if (op == 3'b011) val = v4(36'd0 - t[3], t[2], 36'd0 - t[1], t[0]);
            else bad = 1'b1;
        end else begin
            case (op)
                3'b001: val = v4(fx_mul(s[3], t[3]), fx_mul(s[2], t[2]),
                                 fx_mul(s[1], t[1]), fx_mul(s[0], t[0]));
                3'b010: val = v4(t[3] + s[3], t[2] + s[2], t[1] + s[1], t[0] + s[0]);
                3'b011: val = v4(t[3] - s[3], t[2] - s[2], t[1] - s[1], t[0] - s[0]);
                3'b100: begin
                    fx_cm(t[0], t[1], s[0], s[1], re, im);
                    val = {vd[143:72], im, re};
                end
                3'b101: begin
                    fx_cm(t[0], t[1], s[2], s[3], re, im);
                    val = {im, re, vd[71:0]};
                end
                default: bad = 1'b1;
            endcase
        end
    endtask

    task automatic check_reg(input logic [5:0] a, input string tag);
        rd_ctx = a[5:4];
        rd_idx = a[3:0];
        #1;
        n_chk++;
        if (rd_data !== m[a]) begin
            n_bad++;
            $display("FAIL %s reg %0d: actual=%h expected=%h", tag, a, rd_data, m[a]);
        end
    endtask

    task automatic check_flag(input bit exp, input string tag);
        #1;
        n_chk++;
        if (illegal !== exp) begin
            n_bad++;
            $display("FAIL %s illegal: actual=%b expected=%b", tag, illegal, exp);
        end
    endtask

    // drive one cycle of stimulus on a falling edge, check at the next one
    task automatic step(input bit iv, input logic [17:0] ins, input logic [1:0] c,
                        input bit lv, input logic [5:0] la, input logic [143:0] ldv,
                        input string tag);
        bit bad;
        logic [5:0] dst;
        logic [143:0] val;
        predict(ins, c, bad, dst, val);
        @(negedge clk);
        instr_valid = iv; instr = ins; ctx = c;
        ld_valid = lv; ld_ctx = la[5:4]; ld_idx = la[3:0]; ld_data = ldv;
        @(negedge clk);
        instr_valid = 1'b0; ld_valid = 1'b0;
        if (lv) m[la] = ldv;
        if (iv && !bad) m[dst] = val;
        check_flag(iv && bad, tag);
        if (iv) check_reg(dst, tag);
        if (lv) check_reg(la, tag);
    endtask

    task automatic load(input logic [5:0] a, input logic [143:0] v);
        step(1'b0, 18'd0, 2'd0, 1'b1, a, v, "R2");
    endtask

    task automatic run(input logic [17:0] ins, input logic [1:0] c, input string tag);
        step(1'b1, ins, c, 1'b0, 6'd0, 144'd0, tag);
    endtask

    task automatic sweep(input string tag);
        for (int a = 0; a < 64; a++) check_reg(6'(a), tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int a = 0; a < 64; a++) m[a] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_flag(1'b0, "R1");
        sweep("R1");

        // R2: preloads in context 0
        load(6'd1, v4(HALF, NHLF, MAXV, HALF));
        load(6'd2, v4(HALF, HALF, MINV, QTR));
        load(6'd3, v4(MINV, 36'd1, MAXV, NHLF));
        load(6'd4, rnd144());
        load(6'd5, rnd144());
        load(6'd7, rnd144());
        load(6'd9, v4(36'd1, MINV, 36'd5, MAXV));

        // R4: lane multiply, including 0.5*0.5 and min*min overflow
        run(mk(3'b001, 1'b0, 3'd6, 4'd1, 4'd2), 2'd0, "R4");
        run(mk(3'b001, 1'b0, 3'd6, 4'd3, 4'd3), 2'd0, "R4");
        run(mk(3'b001, 1'b0, 3'd0, 4'd4, 4'd5), 2'd0, "R4");

        // R5: add and subtract with wrap
        run(mk(3'b010, 1'b0, 3'd6, 4'd1, 4'd3), 2'd0, "R5");
        run(mk(3'b011, 1'b0, 3'd6, 4'd3, 4'd9), 2'd0, "R5");
        run(mk(3'b011, 1'b0, 3'd0, 4'd9, 4'd3), 2'd0, "R5");

        // R6: half complex products keep the other half of dest
        run(mk(3'b100, 1'b0, 3'd7, 4'd1, 4'd2), 2'd0, "R6");
        run(mk(3'b101, 1'b0, 3'd7, 4'd4, 4'd5), 2'd0, "R6");
        run(mk(3'b100, 1'b0, 3'd5, 4'd5, 4'd5), 2'd0, "R6");

        // R7: copy and conjugate; s field ignored; min lane wraps
        run(mk(3'b010, 1'b1, 3'd6, 4'd9, 4'd3), 2'd0, "R7");
        run(mk(3'b011, 1'b1, 3'd6, 4'd9, 4'd7), 2'd0, "R7");
        run(mk(3'b011, 1'b1, 3'd4, 4'd2, 4'd0), 2'd0, "R7");

        // R8: undefined encodings write nothing, flag for one cycle
        run(mk(3'b000, 1'b0, 3'd6, 4'd1, 4'd2), 2'd0, "R8");
        run(mk(3'b110, 1'b0, 3'd6, 4'd1, 4'd2), 2'd0, "R8");
        run(mk(3'b111, 1'b0, 3'd6, 4'd1, 4'd2), 2'd0, "R8");
        run(mk(3'b001, 1'b1, 3'd6, 4'd1, 4'd2), 2'd0, "R8");
        run(mk(3'b010, 1'b0, 3'd6, 4'd1, 4'd2) | 18'h20000, 2'd0, "R8");
        step(1'b0, 18'd0, 2'd0, 1'b0, 6'd0, 144'd0, "R8");

        // R3: contexts isolated, bits 9:8 ignored
        load(6'd33, rnd144());
        load(6'd34, rnd144());
        run(mk(3'b010, 1'b0, 3'd6, 4'd1, 4'd2) | 18'h00300, 2'd2, "R3");
        check_reg(6'd6, "R3");
        check_reg(6'd22, "R3");

        // R2: collision, instruction write wins over preload
        step(1'b1, mk(3'b010, 1'b0, 3'd6, 4'd1, 4'd2), 2'd0, 1'b1, 6'd6, rnd144(), "R2");
        check_reg(6'd6, "R2");

        // R9: idle cycles leave all registers unchanged
        repeat (5) @(negedge clk);
        sweep("R9");

        // random mix across contexts (R3..R8)
        for (int i = 0; i < 400; i++) begin
            logic [17:0] ins;
            ins = mk(3'($urandom()), 1'($urandom()), 3'($urandom()),
                     4'($urandom()), 4'($urandom()));
            if ($urandom() % 16 == 0) ins[17] = 1'b1;
            if ($urandom() % 4 == 0)
                step(1'b1, ins, 2'($urandom()), 1'b1, 6'($urandom()), rnd144(), "R3");
            else
                run(ins, 2'($urandom()), "R9");
        end
        sweep("R9");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule